// File: doc/BRIEF.md
# Programmable Almost-Full / Almost-Empty Flag Unit

This block sits beside a dual-clock FIFO and generates two active-low warning flags: almost-empty and almost-full. It tracks the FIFO fill level with a write pointer in the write-clock domain and a read pointer in the read-clock domain. The pointers cross between the domains as Gray codes through two-flop synchronisers. Each flag is compared against a programmable offset. Both offsets live in registers that are written from the 18-bit data bus and can be read back on the 18-bit output bus.

Three modes are captured while master reset is low and then held.

- **Flag timing.** In asynchronous timing, each flag is asserted by the clock whose traffic causes the condition and released by the other clock. In synchronous timing, almost-empty is updated only by the read clock and almost-full only by the write clock.
- **First-word-fall-through.** This mode shifts both thresholds by one word, because a word can sit in the output register.
- **Parity placement.** This mode chooses which two bus bits are treated as parity and skipped when an offset is loaded or read back. The FIFO data path itself is unaffected.

The pointer width `AW` sets the depth as 2^AW words and must not exceed 16. `wr_inc_i` and `rd_inc_i` mark words that the FIFO actually accepts and delivers.

Top module: `pflag_unit`

## Requirements
- R1: The timing, fall-through and parity mode inputs are captured only while `mrst_n` is low; changing them after reset has no effect on flags, offset loading or readback.
- R2: While reset is held and after its release with no traffic, `pae_n_o` is 0 and `paf_n_o` is 1, and both offset registers hold their parameter defaults (`DEF_E` for almost-empty, `DEF_F` for almost-full).
- R3: With fill count c and empty offset n, `pae_n_o` settles to 0 when c <= n in standard mode or c <= n+1 in fall-through mode, and to 1 otherwise.
- R4: With depth D and full offset m, `paf_n_o` settles to 0 when c >= D-m in standard mode or c >= D-m+1 in fall-through mode, and to 1 otherwise.
- R5: In asynchronous timing (`tmode_i`=0 at reset), `pae_n_o` is released by write-clock activity alone while the read clock is stopped, and `paf_n_o` is released by read-clock activity alone while the write clock is stopped.
- R6: In synchronous timing (`tmode_i`=1 at reset), `pae_n_o` does not change while the read clock is stopped, and `paf_n_o` does not change while the write clock is stopped.
- R7: A write-clock edge with `ld_en_i`=1 loads the offset chosen by `ld_sel_i` (0 = empty offset, 1 = full offset) from `din_i`.
- R8: In interspersed parity (`ipar_i`=1 at reset), offset bits 7..0 come from `din_i[7:0]` and bits 15..8 from `din_i[16:9]`. `din_i[8]` and `din_i[17]` are ignored. Readback uses the same placement, with `q_o[8]` and `q_o[17]` driven to 0.
- R9: In non-interspersed parity (`ipar_i`=0 at reset), the offset comes from `din_i[15:0]` and `din_i[17:16]` are ignored. Readback places the offset in `q_o[15:0]` with `q_o[17:16]` driven to 0.
- R10: A read-clock edge with `rb_en_i`=1 loads `q_o` with the offset chosen by `rb_sel_i` (0 = empty, 1 = full), zero-extended above `AW` bits. `q_o` holds its value while `rb_en_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, synchronous in each domain |
| tmode_i | input | 1 | Flag timing select captured at reset: 0 asynchronous, 1 synchronous |
| fwft_i | input | 1 | Fall-through mode captured at reset |
| ipar_i | input | 1 | Parity placement captured at reset: 1 interspersed, 0 upper bits |
| wr_inc_i | input | 1 | One word written this write-clock cycle |
| rd_inc_i | input | 1 | One word read this read-clock cycle |
| ld_en_i | input | 1 | Offset load strobe (write clock) |
| ld_sel_i | input | 1 | Offset load target: 0 empty, 1 full |
| din_i | input | 18 | Data bus carrying the offset value |
| rb_en_i | input | 1 | Offset readback strobe (read clock) |
| rb_sel_i | input | 1 | Readback source: 0 empty, 1 full |
| q_o | output | 18 | Offset readback bus |
| pae_n_o | output | 1 | Almost-empty flag, active low |
| paf_n_o | output | 1 | Almost-full flag, active low |

## Verification
The bench builds the block with `AW`=9, a depth of 512, which makes it affordable to step the fill level one word at a time from empty to full and back. At every step it compares both flags with the arithmetic thresholds, across all eight combinations of the three reset-captured modes. A 9-bit offset also has its bit 8 in use, so the two parity placements put that bit on different bus lines, and a wrong placement or a parity bit that is not ignored shows up in the readback. Each clock is gated separately, so the bench can stop one domain and show which clock is allowed to move each flag in each timing mode.

// File: rtl/pflag_unit.sv
module pflag_unit #(
  parameter int AW    = 10,
  parameter int DEF_E = 7,
  parameter int DEF_F = 7
) (
  input  logic        wclk,
  input  logic        rclk,
  input  logic        mrst_n,
  input  logic        tmode_i,
  input  logic        fwft_i,
  input  logic        ipar_i,
  input  logic        wr_inc_i,
  input  logic        rd_inc_i,
  input  logic        ld_en_i,
  input  logic        ld_sel_i,
  input  logic [17:0] din_i,
  input  logic        rb_en_i,
  input  logic        rb_sel_i,
  output logic [17:0] q_o,
  output logic        pae_n_o,
  output logic        paf_n_o
);
  localparam int PW = AW + 1;
  localparam int CW = AW + 2;
  localparam logic [CW-1:0] DEPTH = CW'(1) << AW;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [17:0] place(input logic [AW-1:0] v, input logic ip);
    logic [15:0] o;
    o = 16'(v);
    return ip ? {1'b0, o[15:8], 1'b0, o[7:0]} : {2'b00, o};
  endfunction

  // write-clock domain state
  logic          md_sync_w, md_fwft_w, md_ip_w;
  logic [PW-1:0] wptr, wgray, rg_w1, rg_w2;
  logic [AW-1:0] off_e, off_f;
  logic          w_tok, rt_w1, rt_w2;
  logic          f_wtok, fr_w1, fr_w2;
  logic          paf_s_n;

  // read-clock domain state
  logic          md_sync_r, md_fwft_r, md_ip_r;
  logic [PW-1:0] rptr, rgray, wg_r1, wg_r2;
  logic          r_tok, wt_r1, wt_r2;
  logic          f_rtok, fw_r1, fw_r2;
  logic          pae_s_n;
  logic [17:0]   q_r;

  logic [PW-1:0] wnxt, rnxt, wcnt, rcnt;
  logic          ae_w, af_w, ae_r, af_r;
  logic [15:0]   din16;
  logic [AW-1:0] ld_val;
  logic          unused_bits;

  assign wnxt = wptr + PW'(wr_inc_i);
  assign rnxt = rptr + PW'(rd_inc_i);
  assign wcnt = wptr - g2b(rg_w2);
  assign rcnt = g2b(wg_r2) - rptr;

  assign ae_w = CW'(wcnt) <= CW'(off_e) + CW'(md_fwft_w);
  assign af_w = CW'(wcnt) + CW'(off_f) >= DEPTH + CW'(md_fwft_w);
  assign ae_r = CW'(rcnt) <= CW'(off_e) + CW'(md_fwft_r);
  assign af_r = CW'(rcnt) + CW'(off_f) >= DEPTH + CW'(md_fwft_r);

  assign din16       = md_ip_w ? {din_i[16:9], din_i[7:0]} : din_i[15:0];
  assign ld_val      = din16[AW-1:0];
  assign unused_bits = ^{din_i[17], din16};

  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      md_sync_w <= tmode_i;
      md_fwft_w <= fwft_i;
      md_ip_w   <= ipar_i;
      wptr      <= '0;
      wgray     <= '0;
      rg_w1     <= '0;
      rg_w2     <= '0;
      off_e     <= AW'(DEF_E);
      off_f     <= AW'(DEF_F);
      w_tok     <= 1'b0;
      rt_w1     <= 1'b1;
      rt_w2     <= 1'b1;
      f_wtok    <= 1'b0;
      fr_w1     <= 1'b0;
      fr_w2     <= 1'b0;
      paf_s_n   <= 1'b1;
    end else begin
      wptr  <= wnxt;
      wgray <= wnxt ^ (wnxt >> 1);
      rg_w1 <= rgray;
      rg_w2 <= rg_w1;
      rt_w1 <= r_tok;
      rt_w2 <= rt_w1;
      fr_w1 <= f_rtok;
      fr_w2 <= fr_w1;
      if (ld_en_i) begin
        if (ld_sel_i) off_f <= ld_val;
        else          off_e <= ld_val;
      end
      if (w_tok != rt_w2 && !ae_w) w_tok <= ~w_tok;
      if (f_wtok == fr_w2 && af_w) f_wtok <= ~f_wtok;
      paf_s_n <= ~af_w;
    end
  end

  always_ff @(posedge rclk) begin
    if (!mrst_n) begin
      md_sync_r <= tmode_i;
      md_fwft_r <= fwft_i;
      md_ip_r   <= ipar_i;
      rptr      <= '0;
      rgray     <= '0;
      wg_r1     <= '0;
      wg_r2     <= '0;
      r_tok     <= 1'b1;
      wt_r1     <= 1'b0;
      wt_r2     <= 1'b0;
      f_rtok    <= 1'b0;
      fw_r1     <= 1'b0;
      fw_r2     <= 1'b0;
      pae_s_n   <= 1'b0;
      q_r       <= '0;
    end else begin
      rptr  <= rnxt;
      rgray <= rnxt ^ (rnxt >> 1);
      wg_r1 <= wgray;
      wg_r2 <= wg_r1;
      wt_r1 <= w_tok;
      wt_r2 <= wt_r1;
      fw_r1 <= f_wtok;
      fw_r2 <= fw_r1;
      if (r_tok == wt_r2 && ae_r) r_tok <= ~r_tok;
      if (f_rtok != fw_r2 && !af_r) f_rtok <= ~f_rtok;
      pae_s_n <= ~ae_r;
      if (rb_en_i) q_r <= place(rb_sel_i ? off_f : off_e, md_ip_r);
    end
  end

  // token pairs: flag asserted while the two domain tokens differ
  assign pae_n_o = md_sync_r ? pae_s_n : ~(r_tok ^ w_tok);
  assign paf_n_o = md_sync_w ? paf_s_n : ~(f_wtok ^ f_rtok);
  assign q_o     = q_r;

  p_modes_held_r1: assert property (@(posedge wclk) disable iff (!mrst_n)
    mrst_n |=> $stable({md_sync_w, md_fwft_w, md_ip_w}));

  p_ae_set_once_r5: assert property (@(posedge rclk) disable iff (!mrst_n)
    (r_tok != $past(r_tok)) |-> $past(r_tok == wt_r2));

  p_af_set_once_r5: assert property (@(posedge wclk) disable iff (!mrst_n)
    (f_wtok != $past(f_wtok)) |-> $past(f_wtok == fr_w2));

  p_rb_interspersed_r8: assert property (@(posedge rclk) disable iff (!mrst_n)
    md_ip_r |-> (q_o[8] == 1'b0 && q_o[17] == 1'b0));

  p_rb_upper_parity_r9: assert property (@(posedge rclk) disable iff (!mrst_n)
    !md_ip_r |-> (q_o[17:16] == 2'b00));
endmodule

// File: tb/pflag_unit_tb_top.sv
`timescale 1ns/1ps
module pflag_unit_tb_top;
  localparam int AW = 9;
  localparam int D  = 512;
  localparam int DE = 5;
  localparam int DF = 6;

  logic wclk_raw = 1'b0, rclk_raw = 1'b0, wrun = 1'b1, rrun = 1'b1;
  logic wclk, rclk;
  logic mrst_n = 1'b0, tmode = 1'b0, fwft = 1'b0, ipar = 1'b0;
  logic wr = 1'b0, rd = 1'b0, ld_en = 1'b0, ld_sel = 1'b0, rb_en = 1'b0, rb_sel = 1'b0;
  logic [17:0] din = '0;
  logic [17:0] q;
  logic pae_n, paf_n;
  int errors = 0, checks = 0;

  assign wclk = wclk_raw & wrun;
  assign rclk = rclk_raw & rrun;

  initial forever #4 wclk_raw = ~wclk_raw;
  initial begin #2; forever #4 rclk_raw = ~rclk_raw; end

  pflag_unit #(.AW(AW), .DEF_E(DE), .DEF_F(DF)) dut_i (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .tmode_i(tmode), .fwft_i(fwft),
    .ipar_i(ipar), .wr_inc_i(wr), .rd_inc_i(rd), .ld_en_i(ld_en), .ld_sel_i(ld_sel),
    .din_i(din), .rb_en_i(rb_en), .rb_sel_i(rb_sel), .q_o(q), .pae_n_o(pae_n), .paf_n_o(paf_n));

  function automatic logic [17:0] pk(input logic ip, input int v);
    logic [15:0] o;
    o = 16'(v);
    return ip ? {1'b0, o[15:8], 1'b0, o[7:0]} : {2'b00, o};
  endfunction

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_n(input int n);
    @(negedge wclk_raw); wr = 1'b1;
    repeat (n) @(negedge wclk_raw);
    wr = 1'b0;
  endtask

  task automatic rd_n(input int n);
    @(negedge rclk_raw); rd = 1'b1;
    repeat (n) @(negedge rclk_raw);
    rd = 1'b0;
  endtask

  task automatic load(input logic sel, input logic [17:0] v);
    @(negedge wclk_raw); ld_en = 1'b1; ld_sel = sel; din = v;
    @(negedge wclk_raw); ld_en = 1'b0; din = '0;
  endtask

  task automatic readback(input logic sel, input logic [17:0] exp, input string req);
    @(negedge rclk_raw); rb_en = 1'b1; rb_sel = sel;
    @(negedge rclk_raw); rb_en = 1'b0;
    chk(req, q, exp);
  endtask

  task automatic run_cfg(input logic sy, input logic fw, input logic ip, input int e, input int f);
    int fwi;
    int n;
    logic [17:0] junk;
    string ptag;
    fwi  = fw ? 1 : 0;
    junk = ip ? 18'h20100 : 18'h30000;
    ptag = ip ? "R8" : "R9";
    @(negedge wclk_raw); mrst_n = 1'b0; tmode = sy; fwft = fw; ipar = ip;
    repeat (4) @(negedge wclk_raw);
    chk("R2 pae_n during reset", {17'd0, pae_n}, 18'd0);
    mrst_n = 1'b1;
    @(negedge wclk_raw); tmode = ~sy; fwft = ~fw; ipar = ~ip;  // R1: pins flipped after reset
    repeat (2) @(negedge wclk_raw);
    chk("R2 pae_n after reset", {17'd0, pae_n}, 18'd0);
    chk("R2 paf_n after reset", {17'd0, paf_n}, 18'd1);
    readback(1'b0, pk(ip, DE), "R2 default empty offset");
    readback(1'b1, pk(ip, DF), "R2 default full offset");
    load(1'b0, pk(ip, e) | junk);                               // R7
    repeat (4) @(negedge rclk_raw);
    chk("R10 q held without strobe", q, pk(ip, DF));
    load(1'b1, pk(ip, f) | junk);
    readback(1'b0, pk(ip, e), {ptag, "/R1/R7 empty offset readback"});
    readback(1'b1, pk(ip, f), {ptag, "/R1/R7 full offset readback"});

    for (int k = 1; k <= D; k++) begin
      wr_n(1);
      repeat (7) @(negedge wclk_raw);
      chk("R3 pae_n filling", {17'd0, pae_n}, (k <= e + fwi) ? 18'd0 : 18'd1);
      chk("R4 paf_n filling", {17'd0, paf_n}, (k >= D - f + fwi) ? 18'd0 : 18'd1);
    end

    @(negedge wclk_raw); wrun = 1'b0;
    rd_n(D - 100);
    repeat (10) @(negedge rclk_raw);
    chk(sy ? "R6 paf_n held with write clock stopped" : "R5 paf_n released by read clock",
        {17'd0, paf_n}, sy ? 18'd0 : 18'd1);
    @(negedge wclk_raw); wrun = 1'b1;
    repeat (10) @(negedge wclk_raw);
    chk("R4 paf_n after write clock restart", {17'd0, paf_n}, 18'd1);

    for (int k = 99; k >= 0; k--) begin
      rd_n(1);
      repeat (7) @(negedge rclk_raw);
      chk("R3 pae_n draining", {17'd0, pae_n}, (k <= e + fwi) ? 18'd0 : 18'd1);
      chk("R4 paf_n draining", {17'd0, paf_n}, (k >= D - f + fwi) ? 18'd0 : 18'd1);
    end

    @(negedge rclk_raw); rrun = 1'b0;
    n = e + fwi + 1;
    wr_n(n);
    repeat (10) @(negedge wclk_raw);
    chk(sy ? "R6 pae_n held with read clock stopped" : "R5 pae_n released by write clock",
        {17'd0, pae_n}, sy ? 18'd0 : 18'd1);
    chk("R4 paf_n with read clock stopped", {17'd0, paf_n}, (n >= D - f + fwi) ? 18'd0 : 18'd1);
    @(negedge rclk_raw); rrun = 1'b1;
    repeat (10) @(negedge rclk_raw);
    chk("R3 pae_n after read clock restart", {17'd0, pae_n}, 18'd1);
  endtask

  initial begin
    repeat (3) @(negedge wclk_raw);
    for (int cfg = 0; cfg < 8; cfg++) begin
      run_cfg(cfg[0], cfg[1], cfg[2], 260 + cfg, 300 + 3 * cfg);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule